// File: doc/BRIEF.md
# Ethernet Receive Frame Status Checker

This block watches the nibble stream that an MII receiver hands over on the receive clock. It qualifies the stream with a data-valid level and a 4-bit data bus. The stream is taken to begin at the first destination-address nibble, with the preamble and start delimiter already removed. For each frame it counts whole octets and runs a CRC-32 over them. When data-valid drops, it reports the frame's length and a set of status flags, together with a one-cycle done strobe.

The status covers the following conditions:
- frames below the minimum size;
- frames above a programmable maximum size, which also raise a live babble pulse while the frame is still arriving;
- a trailing odd nibble (dribble);
- truncation at 2048 octets;
- a receive-FIFO overrun reported by the logic downstream.

The CRC verdict is taken at the last whole-octet boundary, so one dribble nibble never corrupts it. When an overrun is reported, it overrides the length and integrity flags. Buffer handling, address matching and DMA sit around this block and are not part of it.

Top module: `rx_frame_status`

## Requirements
- R1: After reset the following outputs are all 0: `statDone`, `babble`, `statLen` and every status flag. The maximum-length register holds 1518.
- R2: `statLen` reports the number of whole octets from the first nibble through the FCS. Nibbles arrive low half first. The result appears, with `statDone` high, in the cycle after the first clock edge that samples `rxValid` low following a frame.
- R3: `statCrcErr` is 0 exactly when the reflected CRC-32 accumulates to the residue 0xDEBB20E3. The CRC uses polynomial 0xEDB88320, is preset to all ones, is fed LSB first, and runs over all completed octets including the FCS. In non-reflected notation this residue is 0xC704DD7B.
- R4: A frame with an odd nibble count has its last nibble left out of both the length and the CRC. `statNonOctet` is 1 only when the nibble count is odd and `statCrcErr` is also 1.
- R5: `statShort` is 1 when the reported length is below 64.
- R6: `statLong` is 1 when the reported length exceeds the maximum length. `babble` pulses for one cycle, once per frame, in the cycle after the edge that captures the high nibble of octet maximum+1.
- R7: A clock edge with `maxLenWe` high loads `maxLenIn` into the maximum-length register.
- R8: Once 2048 octets have been captured, further nibbles are ignored. `statLen` then reads 2048 and `statTrunc` is 1.
- R9: If `fifoOverrun` is sampled high at any edge while `rxValid` is high, `statOverrun` is 1 and `statLong`, `statShort`, `statCrcErr` and `statNonOctet` are 0. `statLen` and `statTrunc` are unaffected.
- R10: `statDone` is a single-cycle pulse. The length and flags hold their values until the next frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Data-valid level framing the nibble stream |
| rxNibble | input | 4 | Received nibble, low half of each octet first |
| fifoOverrun | input | 1 | Overrun indication from the receive FIFO |
| maxLenWe | input | 1 | Write strobe for the maximum-length register |
| maxLenIn | input | 11 | New maximum length in octets |
| statDone | output | 1 | One-cycle pulse when status is ready |
| statLen | output | 12 | Frame length in octets, including FCS |
| statLong | output | 1 | Frame exceeded the maximum length |
| statShort | output | 1 | Frame below 64 octets |
| statCrcErr | output | 1 | CRC check failed |
| statNonOctet | output | 1 | Odd nibble ending with bad CRC |
| statTrunc | output | 1 | Frame cut at 2048 octets |
| statOverrun | output | 1 | FIFO overrun during the frame |
| babble | output | 1 | Live pulse when the maximum length is passed |

## Verification
The assertions assume the following about the inputs:
- `rxValid` goes low for at least one cycle between frames, so each fall is a distinct frame end.
- `maxLenIn` is written only between frames.
- The stream starts at the destination address.

The bench drives every frame as a contiguous run of nibbles on the falling clock edge, with a gap of at least two idle cycles after each frame. It pulses `fifoOverrun` only inside a frame and reprograms the maximum length only while `rxValid` is low.

// File: rtl/rx_frame_status_pkg.sv
package rx_frame_status_pkg;

  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  typedef struct packed {
    logic frameStart;
    logic nibbleEn;
    logic frameEnd;
  } strb_t;

  typedef struct packed {
    logic longF;
    logic shortF;
    logic crcErr;
    logic nonOctet;
    logic trunc;
    logic overrun;
  } flags_t;

  function automatic logic [31:0] crcNib(input logic [31:0] c, input logic [3:0] n);
    logic [31:0] r;
    r = c ^ {28'd0, n};
    for (int b = 0; b < 4; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rx_frame_status_ctrl.sv
module rx_frame_status_ctrl
  import rx_frame_status_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  rxValid,
  output strb_t strb,
  output logic  done
);

  typedef enum logic {IDLE, RECV} state_t;
  state_t state;

  always_comb begin
    strb.frameStart = rxValid && (state == IDLE);
    strb.nibbleEn   = rxValid;
    strb.frameEnd   = !rxValid && (state == RECV);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      done  <= 1'b0;
    end else begin
      state <= rxValid ? RECV : IDLE;
      done  <= strb.frameEnd;
    end
  end

endmodule

// File: rtl/rx_frame_status_dp.sv
module rx_frame_status_dp
  import rx_frame_status_pkg::*;
#(
  parameter int TRUNC_LEN   = 2048,
  parameter int MIN_LEN     = 64,
  parameter int MAXLEN_W    = 11,
  parameter int MAX_LEN_RST = 1518,
  parameter int LEN_W       = $clog2(TRUNC_LEN + 1)
)(
  input  logic                clk,
  input  logic                rstN,
  input  strb_t               strb,
  input  logic [3:0]          rxNibble,
  input  logic                fifoOverrun,
  input  logic                maxLenWe,
  input  logic [MAXLEN_W-1:0] maxLenIn,
  output logic [LEN_W-1:0]    statLen,
  output flags_t              statFlags,
  output logic                babble
);

  localparam int NIB_W = LEN_W + 1;
  localparam logic [NIB_W-1:0] NIB_CAP = NIB_W'(2 * TRUNC_LEN);

  logic [NIB_W-1:0]    nibCnt;
  logic [LEN_W-1:0]    byteCnt;
  logic [31:0]         crcRun, crcByte, crcNext;
  logic                ovrQ;
  logic                capped;
  logic [MAXLEN_W-1:0] maxLenQ;
  logic [LEN_W-1:0]    maxLenX;
  flags_t              endFlags;

  always_comb begin
    byteCnt = nibCnt[NIB_W-1:1];
    capped  = (nibCnt == NIB_CAP);
    crcNext = crcNib(crcRun, rxNibble);
    maxLenX = LEN_W'(maxLenQ);
  end

  // end-of-frame verdict, overrun masks the integrity flags
  always_comb begin
    endFlags.trunc    = capped;
    endFlags.overrun  = ovrQ;
    endFlags.crcErr   = (crcByte != CRC_RESIDUE) && !ovrQ;
    endFlags.nonOctet = nibCnt[0] && (crcByte != CRC_RESIDUE) && !ovrQ;
    endFlags.shortF   = (byteCnt < LEN_W'(MIN_LEN)) && !ovrQ;
    endFlags.longF    = (byteCnt > maxLenX) && !ovrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibCnt    <= '0;
      crcRun    <= CRC_INIT;
      crcByte   <= CRC_INIT;
      ovrQ      <= 1'b0;
      maxLenQ   <= MAXLEN_W'(MAX_LEN_RST);
      babble    <= 1'b0;
      statLen   <= '0;
      statFlags <= '0;
    end else begin
      babble <= 1'b0;
      if (maxLenWe) maxLenQ <= maxLenIn;
      if (strb.frameStart) begin
        nibCnt  <= NIB_W'(1);
        crcRun  <= crcNib(CRC_INIT, rxNibble);
        crcByte <= CRC_INIT;
        ovrQ    <= fifoOverrun;
      end else if (strb.nibbleEn) begin
        ovrQ <= ovrQ | fifoOverrun;
        if (!capped) begin
          nibCnt <= nibCnt + NIB_W'(1);
          crcRun <= crcNext;
          if (nibCnt[0]) begin
            crcByte <= crcNext;
            if (byteCnt == maxLenX) babble <= 1'b1;
          end
        end
      end
      if (strb.frameEnd) begin
        statLen   <= byteCnt;
        statFlags <= endFlags;
      end
    end
  end

endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rx_frame_status_pkg::*;
#(
  parameter int TRUNC_LEN   = 2048,
  parameter int MIN_LEN     = 64,
  parameter int MAXLEN_W    = 11,
  parameter int MAX_LEN_RST = 1518,
  localparam int LEN_W      = $clog2(TRUNC_LEN + 1)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxValid,
  input  logic [3:0]          rxNibble,
  input  logic                fifoOverrun,
  input  logic                maxLenWe,
  input  logic [MAXLEN_W-1:0] maxLenIn,
  output logic                statDone,
  output logic [LEN_W-1:0]    statLen,
  output logic                statLong,
  output logic                statShort,
  output logic                statCrcErr,
  output logic                statNonOctet,
  output logic                statTrunc,
  output logic                statOverrun,
  output logic                babble
);

  strb_t  strb;
  flags_t flags;

  rx_frame_status_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .strb    (strb),
    .done    (statDone)
  );

  rx_frame_status_dp #(
    .TRUNC_LEN   (TRUNC_LEN),
    .MIN_LEN     (MIN_LEN),
    .MAXLEN_W    (MAXLEN_W),
    .MAX_LEN_RST (MAX_LEN_RST),
    .LEN_W       (LEN_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rxNibble    (rxNibble),
    .fifoOverrun (fifoOverrun),
    .maxLenWe    (maxLenWe),
    .maxLenIn    (maxLenIn),
    .statLen     (statLen),
    .statFlags   (flags),
    .babble      (babble)
  );

  assign statLong     = flags.longF;
  assign statShort    = flags.shortF;
  assign statCrcErr   = flags.crcErr;
  assign statNonOctet = flags.nonOctet;
  assign statTrunc    = flags.trunc;
  assign statOverrun  = flags.overrun;

endmodule

// File: rtl/rx_frame_status_chk.sv
module rx_frame_status_chk #(
  parameter int TRUNC_LEN = 2048,
  parameter int LEN_W     = 12
)(
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             statDone,
  input logic [LEN_W-1:0] statLen,
  input logic             statLong,
  input logic             statShort,
  input logic             statCrcErr,
  input logic             statNonOctet,
  input logic             statTrunc,
  input logic             statOverrun,
  input logic             babble
);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    statDone |=> !statDone);

  assert_done_after_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    statDone |-> (!$past(rxValid) && $past(rxValid, 2)));

  assert_nonoctet_needs_crc_R4: assert property (@(posedge clk) disable iff (!rstN)
    statNonOctet |-> statCrcErr);

  assert_overrun_masks_R9: assert property (@(posedge clk) disable iff (!rstN)
    statOverrun |-> !(statLong || statShort || statCrcErr || statNonOctet));

  assert_trunc_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    statTrunc |-> (statLen == LEN_W'(TRUNC_LEN)));

  assert_len_capped_R8: assert property (@(posedge clk) disable iff (!rstN)
    statLen <= LEN_W'(TRUNC_LEN));

  assert_babble_in_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    babble |-> $past(rxValid));

  assert_babble_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    babble |=> !babble);

endmodule

bind rx_frame_status rx_frame_status_chk #(.TRUNC_LEN(TRUNC_LEN), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/test_rx_frame_status.sv
module test_rx_frame_status;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [3:0]  rxNibble = 4'h0;
  logic        fifoOverrun = 1'b0;
  logic        maxLenWe = 1'b0;
  logic [10:0] maxLenIn = 11'd0;
  logic        statDone, statLong, statShort, statCrcErr, statNonOctet;
  logic        statTrunc, statOverrun, babble;
  logic [11:0] statLen;

  int total = 0;
  int bad = 0;
  int babCnt = 0;
  logic [7:0] frm [0:2099];

  always #10 clk = ~clk;

  rx_frame_status i_rx_frame_status (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxNibble(rxNibble),
    .fifoOverrun(fifoOverrun), .maxLenWe(maxLenWe), .maxLenIn(maxLenIn),
    .statDone(statDone), .statLen(statLen), .statLong(statLong),
    .statShort(statShort), .statCrcErr(statCrcErr), .statNonOctet(statNonOctet),
    .statTrunc(statTrunc), .statOverrun(statOverrun), .babble(babble)
  );

  typedef struct packed {
    int nBytes;
    bit bad;
    bit odd;
    int ovrNib;
    bit eShort;
    bit eLong;
    bit eCrc;
    bit eNon;
    bit eOvr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{64,   1'b0, 1'b0, -1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{64,   1'b1, 1'b0, -1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{63,   1'b0, 1'b0, -1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{100,  1'b0, 1'b1, -1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{100,  1'b1, 1'b1, -1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{1518, 1'b0, 1'b0, -1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1519, 1'b0, 1'b0, -1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{40,   1'b1, 1'b0, 10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{30,   1'b1, 1'b1, -1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{200,  1'b0, 1'b0, 50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{64,   1'b0, 1'b1, -1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [31:0] crcUpd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic bit residueBad(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) c = crcUpd(c, frm[i]);
    return c != 32'hDEBB20E3;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic buildFrame(input int n, input bit corrupt, input int seed);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n - 4; i++) begin
      frm[i] = 8'(i * 13 + seed);
      c = crcUpd(c, frm[i]);
    end
    c = ~c;
    frm[n-4] = c[7:0];
    frm[n-3] = c[15:8];
    frm[n-2] = c[23:16];
    frm[n-1] = c[31:24];
    if (corrupt) frm[2] = frm[2] ^ 8'h40;
  endtask

  task automatic sendFrame(input int nBytes, input bit odd, input int ovrNib);
    int nn;
    nn = 2 * nBytes + (odd ? 1 : 0);
    babCnt = 0;
    for (int k = 0; k < nn; k++) begin
      @(negedge clk);
      if (babble) babCnt++;
      rxValid = 1'b1;
      if (k >= 2 * nBytes) rxNibble = 4'hA;
      else rxNibble = k[0] ? frm[k/2][7:4] : frm[k/2][3:0];
      fifoOverrun = (k == ovrNib);
    end
    @(negedge clk);
    if (babble) babCnt++;
    rxValid = 1'b0;
    fifoOverrun = 1'b0;
    @(negedge clk);
    if (babble) babCnt++;
  endtask

  task automatic writeMax(input int v);
    @(negedge clk);
    maxLenWe = 1'b1;
    maxLenIn = 11'(v);
    @(negedge clk);
    maxLenWe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 done", statDone, 0);
    check("R1 babble", babble, 0);
    check("R1 len", statLen, 0);
    check("R1 flags", {statLong, statShort, statCrcErr, statNonOctet, statTrunc, statOverrun}, 0);

    // table walk: R2 R3 R4 R5 R6 R9 (maximum 1518 from reset, R1)
    for (int v = 0; v < NV; v++) begin
      buildFrame(VECS[v].nBytes, VECS[v].bad, v * 5 + 1);
      sendFrame(VECS[v].nBytes, VECS[v].odd, VECS[v].ovrNib);
      check($sformatf("R10 done v%0d", v), statDone, 1);
      check($sformatf("R2 len v%0d", v), statLen, VECS[v].nBytes);
      check($sformatf("R3 crc v%0d", v), statCrcErr, VECS[v].eCrc);
      check($sformatf("R4 nonoct v%0d", v), statNonOctet, VECS[v].eNon);
      check($sformatf("R5 short v%0d", v), statShort, VECS[v].eShort);
      check($sformatf("R6 long v%0d", v), statLong, VECS[v].eLong);
      check($sformatf("R6 babble v%0d", v), babCnt, (VECS[v].nBytes > 1518) ? 1 : 0);
      check($sformatf("R9 ovr v%0d", v), statOverrun, VECS[v].eOvr);
      check($sformatf("R8 trunc v%0d", v), statTrunc, 0);
      @(negedge clk);
      check($sformatf("R10 pulse v%0d", v), statDone, 0);
    end

    // R10 status held after done
    repeat (5) @(negedge clk);
    check("R10 hold len", statLen, 64);
    check("R10 hold done", statDone, 0);

    // R7 programmable maximum
    writeMax(100);
    buildFrame(101, 1'b0, 9);
    sendFrame(101, 1'b0, -1);
    check("R7 long 101", statLong, 1);
    check("R7 babble 101", babCnt, 1);
    buildFrame(100, 1'b0, 9);
    sendFrame(100, 1'b0, -1);
    check("R7 long 100", statLong, 0);
    check("R7 babble 100", babCnt, 0);

    // R8 truncation at 2048 octets
    writeMax(1518);
    buildFrame(2050, 1'b0, 3);
    sendFrame(2050, 1'b0, -1);
    check("R8 len", statLen, 2048);
    check("R8 trunc", statTrunc, 1);
    check("R8 long", statLong, 1);
    check("R8 crc on first 2048", statCrcErr, residueBad(2048) ? 1 : 0);
    check("R8 babble", babCnt, 1);

    // R9 overrun on the very first nibble, with bad CRC and short frame
    buildFrame(20, 1'b1, 4);
    sendFrame(20, 1'b1, 0);
    check("R9 ovr first", statOverrun, 1);
    check("R9 masked", {statLong, statShort, statCrcErr, statNonOctet}, 0);
    check("R9 len kept", statLen, 20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule